// File: doc/BRIEF.md
# Auto-Shutdown Conversion Sequencer

This block decides when a multichannel analog-to-digital converter is powered, sampling and converting. It rests in a shutdown state. Three sources can request a conversion: a pulse on a convert-start pin, a write of the bus address pointer that carries a convert flag, and a periodic timer whose interval software picks with a small code. For each accepted request the block powers the analog section and holds it in a track (sample) phase for a wake-up interval. It then runs a conversion of fixed length, hands the result to a result register and falls back into shutdown with no further command.

Both intervals are counted in system clocks and derived from parameters that give the clock rate and the interval lengths in nanoseconds. The analog converter is not modelled. Its data input is captured on the last conversion cycle. Register accesses over the bus are not blocked by the sequencer: a pointer write without the convert flag leaves the converter asleep.

Top module: `conv_seq`

## Requirements
- R1: After reset, powerEn, sampleEn, busy and resultValid are all 0.
- R2: A convStart pulse seen while idle raises busy and powerEn on the next clock edge.
- R3: After an accepted trigger, sampleEn is high for exactly WAKE_CYC cycles, with powerEn high, and then drops.
- R4: The conversion phase lasts CONV_CYC cycles after the wake phase; powerEn then returns to 0 with no command.
- R5: busy is high for exactly WAKE_CYC + CONV_CYC cycles, from the accepted trigger until the result is latched, and it falls in the same cycle that resultValid rises.
- R6: resultValid is a one-cycle strobe; with it, resultChan carries the trigger's channel and resultData the adcData value present on the last conversion cycle.
- R7: cmdWrite with cmdConvert = 1 starts a conversion on cmdChan; cmdWrite with cmdConvert = 0 leaves busy and powerEn at 0.
- R8: With cycleCode = k (1 to 7), timer conversions on chanSel repeat every TICK_CYC << (k-1) cycles; cycleCode = 0 starts none and clears the timer.
- R9: A trigger arriving while busy is ignored: no extra conversion follows, and the channel in progress is kept.
- R10: When convStart and a convert command arrive together, convStart wins and chanSel gives the channel; command beats timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| convStart | input | 1 | Convert-start pin pulse |
| chanSel | input | CHAN_W | Channel for pin and timer triggers |
| cmdWrite | input | 1 | Bus address-pointer write strobe |
| cmdConvert | input | 1 | Convert flag of that write |
| cmdChan | input | CHAN_W | Channel named by that write |
| cycleCode | input | 3 | Automatic interval code, 0 = off |
| adcData | input | DATA_W | Stand-in converter output |
| powerEn | output | 1 | Analog power enable |
| sampleEn | output | 1 | Track phase enable |
| busy | output | 1 | Conversion in progress |
| resultValid | output | 1 | One-cycle result strobe |
| resultChan | output | CHAN_W | Channel of the latched result |
| resultData | output | DATA_W | Latched conversion result |

## Verification
The assertions take convStart and convert commands as single-cycle pulses and cycleCode as a level that changes rarely. They also assume adcData holds steady through a conversion, so the captured value is fixed. The bench drives every input on the falling clock edge, pulses triggers for one cycle only, holds adcData constant over each conversion, and changes cycleCode only after passing through 0.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  parameter int CHAN_W = 2;
  parameter int CODE_W = 3;

  typedef enum logic [1:0] {
    ST_SHUT = 2'd0,
    ST_WAKE = 2'd1,
    ST_CONV = 2'd2
  } seqState_t;

  typedef struct packed {
    logic              load;
    logic [CHAN_W-1:0] chan;
  } seqStrobe_t;
endpackage

// File: rtl/conv_seq_timer.sv
module conv_seq_timer #(
  parameter int TICK_CYC = 1000
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [conv_seq_pkg::CODE_W-1:0]  cycleCode,
  output logic                             timerFire
);
  localparam int MAX_SHIFT = (1 << conv_seq_pkg::CODE_W) - 2;
  localparam int TMR_W     = $clog2(TICK_CYC) + MAX_SHIFT + 1;

  logic [TMR_W-1:0] tickCnt;
  logic [TMR_W-1:0] period;

  always_comb begin
    period = TMR_W'(TICK_CYC);
    if (cycleCode != '0) period = TMR_W'(TICK_CYC) << (cycleCode - 1'b1);
  end

  assign timerFire = (cycleCode != '0) && (tickCnt == period - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || cycleCode == '0) tickCnt <= '0;
    else if (timerFire)            tickCnt <= '0;
    else                           tickCnt <= tickCnt + 1'b1;
  end

  // R8: a disabled timer restarts from zero and cannot fire on the next cycle
  assert_timer_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleCode == '0) |=> (tickCnt == '0 || cycleCode != '0));
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl #(
  parameter int WAKE_CYC = 200,
  parameter int CONV_CYC = 400
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              convStart,
  input  logic [conv_seq_pkg::CHAN_W-1:0]   chanSel,
  input  logic                              cmdWrite,
  input  logic                              cmdConvert,
  input  logic [conv_seq_pkg::CHAN_W-1:0]   cmdChan,
  input  logic                              timerFire,
  output logic                              powerEn,
  output logic                              sampleEn,
  output logic                              busy,
  output conv_seq_pkg::seqStrobe_t          strobe
);
  import conv_seq_pkg::*;

  localparam int MAX_CYC = (WAKE_CYC > CONV_CYC) ? WAKE_CYC : CONV_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t         state;
  logic [CNT_W-1:0]  phaseCnt;
  logic [CHAN_W-1:0] curChan;
  logic              cmdTrig, anyTrig, wakeDone, convDone;
  logic [CHAN_W-1:0] trigChan;

  assign cmdTrig  = cmdWrite && cmdConvert;
  assign anyTrig  = convStart || cmdTrig || timerFire;
  assign wakeDone = (phaseCnt == CNT_W'(WAKE_CYC - 1));
  assign convDone = (phaseCnt == CNT_W'(CONV_CYC - 1));

  always_comb begin
    if (convStart)    trigChan = chanSel;
    else if (cmdTrig) trigChan = cmdChan;
    else              trigChan = chanSel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_SHUT;
      phaseCnt <= '0;
      curChan  <= '0;
    end else begin
      case (state)
        ST_SHUT: if (anyTrig) begin
          state    <= ST_WAKE;
          phaseCnt <= '0;
          curChan  <= trigChan;
        end
        ST_WAKE: if (wakeDone) begin
          state    <= ST_CONV;
          phaseCnt <= '0;
        end else phaseCnt <= phaseCnt + 1'b1;
        ST_CONV: if (convDone) begin
          state    <= ST_SHUT;
          phaseCnt <= '0;
        end else phaseCnt <= phaseCnt + 1'b1;
        default: state <= ST_SHUT;
      endcase
    end
  end

  assign busy        = (state != ST_SHUT);
  assign powerEn     = (state == ST_WAKE) || (state == ST_CONV);
  assign sampleEn    = (state == ST_WAKE);
  assign strobe.load = (state == ST_CONV) && convDone;
  assign strobe.chan = curChan;

  // R3: every accepted trigger opens with powered tracking
  assert_wake_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sampleEn && powerEn));
  // R9: channel of a running conversion does not move
  assert_chan_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(curChan));
  // R4: phase counter stays inside the longest phase
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phaseCnt < CNT_W'(MAX_CYC)));
endmodule

// File: rtl/conv_seq_datapath.sv
module conv_seq_datapath #(
  parameter int DATA_W = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  conv_seq_pkg::seqStrobe_t          strobe,
  input  logic [DATA_W-1:0]                 adcData,
  output logic                              resultValid,
  output logic [conv_seq_pkg::CHAN_W-1:0]   resultChan,
  output logic [DATA_W-1:0]                 resultData
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultValid <= 1'b0;
      resultChan  <= '0;
      resultData  <= '0;
    end else begin
      resultValid <= strobe.load;
      if (strobe.load) begin
        resultChan <= strobe.chan;
        resultData <= adcData;
      end
    end
  end

  // R6: the result strobe lasts a single cycle
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |=> !resultValid);
endmodule

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int CLK_MHZ  = 200,
  parameter int WAKE_NS  = 1000,
  parameter int CONV_NS  = 2000,
  parameter int TICK_CYC = 1000,
  parameter int DATA_W   = 12
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             convStart,
  input  logic [conv_seq_pkg::CHAN_W-1:0]  chanSel,
  input  logic                             cmdWrite,
  input  logic                             cmdConvert,
  input  logic [conv_seq_pkg::CHAN_W-1:0]  cmdChan,
  input  logic [conv_seq_pkg::CODE_W-1:0]  cycleCode,
  input  logic [DATA_W-1:0]                adcData,
  output logic                             powerEn,
  output logic                             sampleEn,
  output logic                             busy,
  output logic                             resultValid,
  output logic [conv_seq_pkg::CHAN_W-1:0]  resultChan,
  output logic [DATA_W-1:0]                resultData
);
  localparam int WAKE_CYC = (WAKE_NS * CLK_MHZ + 999) / 1000;
  localparam int CONV_CYC = (CONV_NS * CLK_MHZ + 999) / 1000;

  conv_seq_pkg::seqStrobe_t strobe;
  logic timerFire;

  conv_seq_timer #(.TICK_CYC(TICK_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .cycleCode(cycleCode), .timerFire(timerFire));

  conv_seq_ctrl #(.WAKE_CYC(WAKE_CYC), .CONV_CYC(CONV_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .convStart(convStart), .chanSel(chanSel),
    .cmdWrite(cmdWrite), .cmdConvert(cmdConvert), .cmdChan(cmdChan),
    .timerFire(timerFire), .powerEn(powerEn), .sampleEn(sampleEn),
    .busy(busy), .strobe(strobe));

  conv_seq_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .adcData(adcData),
    .resultValid(resultValid), .resultChan(resultChan), .resultData(resultData));

  // R5: busy ends exactly when the result appears
  assert_busy_to_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> resultValid);
  // R4: once the result is out the analog section is off
  assert_auto_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> !powerEn);
endmodule

// File: tb/conv_seq_bench.sv
`timescale 1ns/1ps
module conv_seq_bench;
  localparam int WAKE = 200;
  localparam int CONV = 400;
  localparam int TICK = 1000;
  localparam int DW   = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic convStart = 1'b0, cmdWrite = 1'b0, cmdConvert = 1'b0;
  logic [1:0] chanSel = '0, cmdChan = '0;
  logic [2:0] cycleCode = '0;
  logic [DW-1:0] adcData = '0;
  logic powerEn, sampleEn, busy, resultValid;
  logic [1:0] resultChan;
  logic [DW-1:0] resultData;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  conv_seq u_conv_seq (
    .clk(clk), .rst_n(rst_n), .convStart(convStart), .chanSel(chanSel),
    .cmdWrite(cmdWrite), .cmdConvert(cmdConvert), .cmdChan(cmdChan),
    .cycleCode(cycleCode), .adcData(adcData), .powerEn(powerEn),
    .sampleEn(sampleEn), .busy(busy), .resultValid(resultValid),
    .resultChan(resultChan), .resultData(resultData));

  // source: 0 pin, 1 command
  typedef struct packed {
    logic        src;
    logic [1:0]  pinCh;
    logic [1:0]  cmdCh;
    logic [11:0] data;
    logic [1:0]  expCh;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b0, 2'd2, 2'd0, 12'h5A3, 2'd2},
    '{1'b1, 2'd0, 2'd3, 12'hFFF, 2'd3},
    '{1'b0, 2'd1, 2'd2, 12'h000, 2'd1},
    '{1'b1, 2'd3, 2'd1, 12'h801, 2'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Called one negedge after the trigger edge; follows the conversion to its end.
  task automatic followConv(input int expCh, input int expData);
    int busyCyc = 0, sampCyc = 0, pwrCyc = 0;
    check(busy && powerEn, "R2", int'(busy), 1);
    while (busy && busyCyc < 5000) begin
      busyCyc++;
      if (sampleEn) sampCyc++;
      if (powerEn) pwrCyc++;
      if (sampleEn && busyCyc > sampCyc) check(0, "R3 sample after conv", busyCyc, sampCyc);
      @(negedge clk);
    end
    check(sampCyc == WAKE, "R3", sampCyc, WAKE);
    check(pwrCyc == WAKE + CONV, "R4", pwrCyc, WAKE + CONV);
    check(busyCyc == WAKE + CONV, "R5", busyCyc, WAKE + CONV);
    check(resultValid, "R5 strobe with busy fall", int'(resultValid), 1);
    check(!powerEn, "R4 off", int'(powerEn), 0);
    check(int'(resultChan) == expCh, "R6 chan", int'(resultChan), expCh);
    check(int'(resultData) == expData, "R6 data", int'(resultData), expData);
    @(negedge clk);
    check(!resultValid, "R6 one cycle", int'(resultValid), 0);
  endtask

  // waits for resultValid, returns cycles waited
  task automatic waitResult(output int n);
    n = 0;
    while (!resultValid && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int n1, n2;
    bit seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!powerEn && !sampleEn, "R1 power", int'(powerEn), 0);
    check(!busy && !resultValid, "R1 busy", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy, "R1 after release", int'(busy), 0);

    // table walk: pin and command triggers
    foreach (VECS[i]) begin
      adcData = VECS[i].data;
      chanSel = VECS[i].pinCh;
      cmdChan = VECS[i].cmdCh;
      if (VECS[i].src) begin cmdWrite = 1'b1; cmdConvert = 1'b1; end
      else convStart = 1'b1;
      @(negedge clk);
      convStart = 1'b0; cmdWrite = 1'b0; cmdConvert = 1'b0;
      followConv(int'(VECS[i].expCh), int'(VECS[i].data));  // R2 R7
      repeat (3) @(negedge clk);
    end

    // R7: pointer write without convert flag keeps converter asleep
    cmdWrite = 1'b1; cmdConvert = 1'b0; cmdChan = 2'd2;
    @(negedge clk);
    cmdWrite = 1'b0;
    seen = 1'b0;
    repeat (20) begin
      if (busy || powerEn) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R7 no convert", int'(seen), 0);

    // R10: pin beats command
    chanSel = 2'd1; cmdChan = 2'd2; adcData = 12'h3C3;
    convStart = 1'b1; cmdWrite = 1'b1; cmdConvert = 1'b1;
    @(negedge clk);
    convStart = 1'b0; cmdWrite = 1'b0; cmdConvert = 1'b0;
    followConv(1, 12'h3C3);

    // R9: triggers while busy are ignored
    chanSel = 2'd0; adcData = 12'h111;
    convStart = 1'b1;
    @(negedge clk);
    convStart = 1'b0;
    repeat (50) @(negedge clk);
    chanSel = 2'd3; cmdChan = 2'd2;
    convStart = 1'b1; cmdWrite = 1'b1; cmdConvert = 1'b1;
    @(negedge clk);
    convStart = 1'b0; cmdWrite = 1'b0; cmdConvert = 1'b0;
    waitResult(n1);
    check(resultChan == 2'd0, "R9 chan kept", int'(resultChan), 0);
    seen = 1'b0;
    repeat (100) begin
      @(negedge clk);
      if (busy || resultValid) seen = 1'b1;
    end
    check(!seen, "R9 no extra conversion", int'(seen), 0);

    // R8: automatic mode, code 1 then code 2
    chanSel = 2'd2; adcData = 12'h0AB;
    cycleCode = 3'd1;
    waitResult(n1);
    check(resultChan == 2'd2 && resultData == 12'h0AB, "R8 timer chan", int'(resultChan), 2);
    @(negedge clk);
    waitResult(n2);
    check(n2 + 1 == TICK, "R8 period code1", n2 + 1, TICK);
    cycleCode = 3'd0;
    repeat (700) @(negedge clk);
    cycleCode = 3'd2;
    waitResult(n1);
    @(negedge clk);
    waitResult(n2);
    check(n2 + 1 == 2 * TICK, "R8 period code2", n2 + 1, 2 * TICK);
    cycleCode = 3'd0;
    repeat (700) @(negedge clk);
    seen = 1'b0;
    repeat (3 * TICK) begin
      @(negedge clk);
      if (busy || resultValid) seen = 1'b1;
    end
    check(!seen, "R8 code zero off", int'(seen), 0);

    finishRun();
  end
endmodule